// File: doc/BRIEF.md
# Parallel-Bus TFT Controller Bring-Up Sequencer

This block brings a parallel-bus TFT display controller out of reset without help from a processor. After a synchronous reset it reads a 40-entry command store one entry at a time and plays each entry out as one write cycle on the display bus. Each write cycle drives an 8-bit byte and a command/parameter select line, holds read/write at write, and pulses an active-low chip select. It pauses for a fixed interval at two points in the sequence: after the soft-reset burst, and after the controller's PLL has been started. When the last entry has been written, it raises a completion flag.

Bus timing comes from a divided enable tick, so the display bus runs well below the core clock. With the default divider of 10 and a 100 MHz core clock, the bus runs at 10 MHz. The divider must be at least 2. All bus outputs come from registers. The select bit is loaded one bus tick before the byte, and both stay unchanged for the whole time chip select is low.

The sequence programs the controller in this order:
1. Soft reset.
2. PLL start.
3. PLL lock.
4. Panel mode for a 640x480 panel.
5. An 8-bit host interface.
6. An 18-bit pixel format.
7. The pixel clock.
8. The horizontal and vertical period settings.

Top module: `tftinit_seq`

## Requirements
- R1: While reset is high, and on the first bus tick after it, chip select (`lcd_cs_n`) and read/write (`lcd_rw_n`) are high and `init_done` is low.
- R2: Each stored entry is 9 bits wide. Bit 8 selects the write type: 0 means a command, written with `lcd_dc`=0, and 1 means a parameter, written with `lcd_dc`=1. Bits 7:0 are driven on `lcd_db` during the write.
- R3: The first three writes are the command 0x01. A wait follows them.
- R4: Writes 3 to 6 are, in order: command 0xE0, parameter 0x01, a wait, command 0xE0, parameter 0x03.
- R5: Writes 7 to 39 are, in order:
  - command 0xB0 with parameters 0C 80 02 7F 01 DF 00
  - command 0xF0 with parameter 00
  - command 0x3A with parameter 60
  - command 0xE6 with parameters 04 FF FF
  - command 0xB4 with parameters 02 F8 00 44 0F 00 00 00
  - command 0xB6 with parameters 01 F8 00 13 07 00 00
- R6: Whenever `lcd_cs_n` is low, `lcd_rw_n` is low, and `lcd_db` and `lcd_dc` do not change.
- R7: Each write holds `lcd_cs_n` low for exactly HOLD_TICKS*CLK_DIV clocks.
- R8: Between two writes with no wait between them, `lcd_cs_n` stays high for exactly (GAP_TICKS+2)*CLK_DIV clocks. This is always at least one clock.
- R9: After write 2 and after write 4, the high time between writes grows by WAIT_TICKS*CLK_DIV clocks.
- R10: `init_done` rises GAP_TICKS*CLK_DIV clocks after the last write ends. It then stays high, with `lcd_cs_n` high and no further writes, until reset.
- R11: A reset at any point, including while `lcd_cs_n` is low, drives `lcd_cs_n` high at the next clock. When reset is released, the sequence restarts from entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| lcd_db | output | 8 | Display data bus byte |
| lcd_dc | output | 1 | 0 = command write, 1 = parameter write |
| lcd_rw_n | output | 1 | Read/write line, low means write |
| lcd_cs_n | output | 1 | Active-low chip select / write strobe |
| init_done | output | 1 | High once the whole sequence has been written |

## Verification
A wrong entry index or a corrupted stored word appears at the ports on the very next write, as a byte or select value that does not match its place in the expected list. A stuck or miscounted state counter changes the width of the chip-select low pulse, or of the high gap, within one write period. A missed or misplaced wait point appears as a gap that is shorter or longer than expected, after entry 2 or 4. Every strobed write is captured with its timing, so each of these faults is seen at the first write it affects.

// File: rtl/tftinit_pkg.sv
package tftinit_pkg;

  localparam int ENTRIES  = 40;
  localparam int IDX_W    = $clog2(ENTRIES);
  localparam int WORD_W   = 9;
  localparam int SEL_BIT  = 8;
  localparam int WAIT_IDX_A = 2;
  localparam int WAIT_IDX_B = 4;

  typedef enum logic [2:0] {
    S_SEL, S_DAT, S_STB, S_GAP, S_WAIT, S_DONE
  } seq_state_t;

  // bit 8: 0 = command, 1 = parameter
  function automatic logic [WORD_W-1:0] init_word(input logic [IDX_W-1:0] i);
    logic [WORD_W-1:0] w;
    case (i)
      6'd0, 6'd1, 6'd2: w = {1'b0, 8'h01};
      6'd3:  w = {1'b0, 8'hE0};
      6'd4:  w = {1'b1, 8'h01};
      6'd5:  w = {1'b0, 8'hE0};
      6'd6:  w = {1'b1, 8'h03};
      6'd7:  w = {1'b0, 8'hB0};
      6'd8:  w = {1'b1, 8'h0C};
      6'd9:  w = {1'b1, 8'h80};
      6'd10: w = {1'b1, 8'h02};
      6'd11: w = {1'b1, 8'h7F};
      6'd12: w = {1'b1, 8'h01};
      6'd13: w = {1'b1, 8'hDF};
      6'd14: w = {1'b1, 8'h00};
      6'd15: w = {1'b0, 8'hF0};
      6'd16: w = {1'b1, 8'h00};
      6'd17: w = {1'b0, 8'h3A};
      6'd18: w = {1'b1, 8'h60};
      6'd19: w = {1'b0, 8'hE6};
      6'd20: w = {1'b1, 8'h04};
      6'd21: w = {1'b1, 8'hFF};
      6'd22: w = {1'b1, 8'hFF};
      6'd23: w = {1'b0, 8'hB4};
      6'd24: w = {1'b1, 8'h02};
      6'd25: w = {1'b1, 8'hF8};
      6'd26: w = {1'b1, 8'h00};
      6'd27: w = {1'b1, 8'h44};
      6'd28: w = {1'b1, 8'h0F};
      6'd29, 6'd30, 6'd31: w = {1'b1, 8'h00};
      6'd32: w = {1'b0, 8'hB6};
      6'd33: w = {1'b1, 8'h01};
      6'd34: w = {1'b1, 8'hF8};
      6'd35: w = {1'b1, 8'h00};
      6'd36: w = {1'b1, 8'h13};
      6'd37: w = {1'b1, 8'h07};
      6'd38, 6'd39: w = {1'b1, 8'h00};
      default: w = {1'b1, 8'h00};
    endcase
    return w;
  endfunction

endpackage

// File: rtl/tftinit_tick.sv
module tftinit_tick #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = (cnt == CW'(DIV - 1));

  // R7
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

endmodule

// File: rtl/tftinit_rom.sv
module tftinit_rom
  import tftinit_pkg::*;
(
  input  logic              clk,
  input  logic [IDX_W-1:0]  addr,
  output logic [WORD_W-1:0] q
);
  // registered read so the store maps onto a block RAM / LUT ROM
  always_ff @(posedge clk) begin
    q <= init_word(addr);
  end
endmodule

// File: rtl/tftinit_seq.sv
module tftinit_seq
  import tftinit_pkg::*;
#(
  parameter int CLK_DIV    = 10,
  parameter int HOLD_TICKS = 2,
  parameter int GAP_TICKS  = 1,
  parameter int WAIT_TICKS = 255
) (
  input  logic       clk,
  input  logic       rst,
  output logic [7:0] lcd_db,
  output logic       lcd_dc,
  output logic       lcd_rw_n,
  output logic       lcd_cs_n,
  output logic       init_done
);
  localparam int MAXT_A = (HOLD_TICKS > GAP_TICKS) ? HOLD_TICKS : GAP_TICKS;
  localparam int MAXT   = (MAXT_A > WAIT_TICKS) ? MAXT_A : WAIT_TICKS;
  localparam int CW     = $clog2(MAXT + 1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic              tick;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] word;
  logic [CW-1:0]     cnt;
  seq_state_t        st;
  logic              wait_pt;

  tftinit_tick #(.DIV(CLK_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  tftinit_rom u_rom (
    .clk  (clk),
    .addr (idx),
    .q    (word)
  );

  assign wait_pt = (idx == IDX_W'(WAIT_IDX_A)) || (idx == IDX_W'(WAIT_IDX_B));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_SEL;
      idx       <= '0;
      cnt       <= '0;
      lcd_db    <= '0;
      lcd_dc    <= 1'b0;
      lcd_rw_n  <= 1'b1;
      lcd_cs_n  <= 1'b1;
      init_done <= 1'b0;
    end else if (tick) begin
      case (st)
        S_SEL: begin
          lcd_dc <= word[SEL_BIT];
          st     <= S_DAT;
        end
        S_DAT: begin
          lcd_db   <= word[7:0];
          lcd_cs_n <= 1'b0;
          lcd_rw_n <= 1'b0;
          cnt      <= '0;
          st       <= S_STB;
        end
        S_STB: begin
          if (cnt == CW'(HOLD_TICKS - 1)) begin
            lcd_cs_n <= 1'b1;
            lcd_rw_n <= 1'b1;
            cnt      <= '0;
            st       <= S_GAP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_GAP: begin
          if (cnt == CW'(GAP_TICKS - 1)) begin
            cnt <= '0;
            if (idx == LAST) begin
              init_done <= 1'b1;
              st        <= S_DONE;
            end else if (wait_pt) begin
              st <= S_WAIT;
            end else begin
              idx <= idx + 1'b1;
              st  <= S_SEL;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WAIT: begin
          if (cnt == CW'(WAIT_TICKS - 1)) begin
            cnt <= '0;
            idx <= idx + 1'b1;
            st  <= S_SEL;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_DONE;
      endcase
    end
  end

  // R6
  rw_during_cs_chk: assert property (@(posedge clk) disable iff (rst)
    !lcd_cs_n |-> !lcd_rw_n);

  // R6
  bus_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!lcd_cs_n && $past(!lcd_cs_n)) |-> ($stable(lcd_db) && $stable(lcd_dc)));

  // R8
  cs_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lcd_cs_n) |=> lcd_cs_n);

  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    init_done |=> (init_done && lcd_cs_n));

  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    idx <= LAST);

endmodule

// File: tb/test_tftinit_seq.sv
module test_tftinit_seq;
  localparam int CLK_DIV = 10;
  localparam int HOLD    = 2;
  localparam int GAP     = 1;
  localparam int WAITT   = 255;
  localparam int N       = 40;

  // expected writes: bit 8 = 1 parameter, 0 command
  localparam logic [8:0] EXP [N] = '{
    9'h001, 9'h001, 9'h001,
    9'h0E0, 9'h101, 9'h0E0, 9'h103,
    9'h0B0, 9'h10C, 9'h180, 9'h102, 9'h17F, 9'h101, 9'h1DF, 9'h100,
    9'h0F0, 9'h100,
    9'h03A, 9'h160,
    9'h0E6, 9'h104, 9'h1FF, 9'h1FF,
    9'h0B4, 9'h102, 9'h1F8, 9'h100, 9'h144, 9'h10F, 9'h100, 9'h100, 9'h100,
    9'h0B6, 9'h101, 9'h1F8, 9'h100, 9'h113, 9'h107, 9'h100, 9'h100
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] lcd_db;
  logic       lcd_dc, lcd_rw_n, lcd_cs_n, init_done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  tftinit_seq #(.CLK_DIV(CLK_DIV), .HOLD_TICKS(HOLD), .GAP_TICKS(GAP),
                .WAIT_TICKS(WAITT)) i_tftinit_seq (
    .clk(clk), .rst(rst), .lcd_db(lcd_db), .lcd_dc(lcd_dc),
    .lcd_rw_n(lcd_rw_n), .lcd_cs_n(lcd_cs_n), .init_done(init_done)
  );

  always #5 clk = ~clk;

  // bus monitor
  int         cyc = 0;
  int         nw = 0;
  logic [8:0] cap_w [64];
  int         fall_c [64];
  int         rise_c [64];
  int         done_c = -1;
  logic       prev_cs = 1'b1;
  logic       prev_done = 1'b0;
  logic [8:0] held = '0;
  int         viol_rw = 0;
  int         viol_stab = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      nw = 0; prev_cs = 1'b1; prev_done = 1'b0; done_c = -1;
    end else begin
      if (prev_cs && !lcd_cs_n) begin
        if (nw < 64) fall_c[nw] = cyc;
        held = {lcd_dc, lcd_db};
      end
      if (!lcd_cs_n && !prev_cs && ({lcd_dc, lcd_db} != held)) viol_stab++;
      if (!lcd_cs_n && lcd_rw_n) viol_rw++;
      if (!prev_cs && lcd_cs_n && nw < 64) begin
        cap_w[nw] = held; rise_c[nw] = cyc; nw++;
      end
      if (!prev_done && init_done) done_c = cyc;
      prev_cs = lcd_cs_n; prev_done = init_done;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_done();
    for (int k = 0; k < 20000 && !init_done; k++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_run();
    chk(nw == N, "R10", "write count", nw, N);
    for (int i = 0; i < N; i++) begin
      string r;
      r = (i < 3) ? "R3" : (i < 7) ? "R4" : "R5";
      chk(cap_w[i] == EXP[i], r, $sformatf("R2 word %0d", i), cap_w[i], EXP[i]);
      chk(rise_c[i] - fall_c[i] == HOLD * CLK_DIV, "R7",
          $sformatf("low len %0d", i), rise_c[i] - fall_c[i], HOLD * CLK_DIV);
      if (i < N - 1) begin
        int e;
        e = (GAP + 2) * CLK_DIV + ((i == 2 || i == 4) ? WAITT * CLK_DIV : 0);
        chk(fall_c[i+1] - rise_c[i] == e, (i == 2 || i == 4) ? "R9" : "R8",
            $sformatf("gap %0d", i), fall_c[i+1] - rise_c[i], e);
      end
    end
    chk(done_c - rise_c[N-1] == GAP * CLK_DIV, "R10", "done delay",
        done_c - rise_c[N-1], GAP * CLK_DIV);
    chk(viol_rw == 0, "R6", "rw high during cs", viol_rw, 0);
    chk(viol_stab == 0, "R6", "bus changed during cs", viol_stab, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(lcd_cs_n == 1 && lcd_rw_n == 1 && init_done == 0, "R1", "reset outputs",
        {lcd_cs_n, lcd_rw_n, init_done}, 3'b110);
    rst = 1'b0;
    repeat (CLK_DIV) @(negedge clk);
    chk(lcd_cs_n == 1 && init_done == 0, "R1", "after release",
        {lcd_cs_n, init_done}, 2'b10);
    wait_done();
    check_run();
    // R10 sticky, no further writes
    repeat (400) @(negedge clk);
    chk(init_done == 1 && lcd_cs_n == 1 && nw == N, "R10", "sticky done",
        {init_done, lcd_cs_n, 8'(nw)}, {2'b11, 8'(N)});
    // R11 reset from done
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(init_done == 0 && lcd_cs_n == 1, "R11", "reset clears done",
        {init_done, lcd_cs_n}, 2'b01);
    rst = 1'b0;
    // R11 reset in the middle of a strobe
    for (int k = 0; k < 5000 && !(nw == 2 && !lcd_cs_n); k++) @(negedge clk);
    chk(!lcd_cs_n, "R11", "mid strobe reached", lcd_cs_n, 0);
    rst = 1'b1;
    @(negedge clk);
    chk(lcd_cs_n == 1 && lcd_rw_n == 1, "R11", "cs high after reset",
        {lcd_cs_n, lcd_rw_n}, 2'b11);
    @(negedge clk);
    rst = 1'b0;
    wait_done();
    check_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(100000 * 10);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", nw, N);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule